// File: doc/BRIEF.md
# Degradable-Width Flit Serializer and Deserializer

This block carries 80-bit link flits across a narrow group of data lanes. On the send side it accepts a 64-bit payload and an 8-bit link header through a valid/ready handshake. It computes an 8-bit CRC over the header and payload together and prepends it. It then streams the flit onto the lane group, most significant bits first. The core clock runs at a single rate. Double-rate signalling is modelled by carrying two slices in each clock beat: the upper half of the lane bus is the earlier slice and the lower half is the later one.

The lane group is made of four quadrants of five lanes. If lanes fail, the group can be narrowed to the lower two quadrants or to the lowest quadrant alone. A narrower group needs more slices, and so more beats, for each flit. The width is picked per flit. The sender samples it when a flit is accepted, and the receiver samples it on the first beat of a flit. A change therefore only takes effect at a flit boundary.

The receive side collects beats into a flit and recomputes the CRC. It presents the header and payload with a one-cycle valid pulse, together with a flag that is set when the carried CRC does not match. Lanes outside the active quadrants are driven to zero on send and ignored on receive.

Top module: `flit_lane_link`

## Requirements
- R1: The flit is laid out as bits [79:72] CRC, [71:64] header and [63:0] payload. The CRC is CRC-8 with polynomial 0x07 and initial value 0x00. It is computed most significant bit first over the 72 bits {header, payload}, with no final inversion.
- R2: Width code 0 (full width) uses all 20 lanes and sends a flit in 2 beats. Each beat carries two 20-bit slices, with the earlier slice on lane bus bits [39:20] and the later slice on bits [19:0]. Across the flit, the slices are flit bits [79:60], [59:40], [39:20] and [19:0], in that order.
- R3: Width code 1 (half width) uses quadrants 0 and 1, which are bits [9:0] of each 20-bit slice position. It sends a flit in 4 beats as eight 10-bit slices, taken from the flit most significant first.
- R4: Width code 2 (quarter width), and the reserved code 3, use quadrant 0 only, which is bits [4:0] of each slice position. They send a flit in 8 beats as sixteen 5-bit slices, taken most significant first.
- R5: While a flit is being sent at reduced width, every lane bus bit outside the active quadrants is 0.
- R6: The send width is sampled only when a flit is accepted. Changing the width input while a flit is being sent does not alter that flit.
- R7: tx_ready is high when no flit is in progress and on the last beat of a flit, and low on every other beat. tx_lane_valid stays high for exactly the beats of a flit with no gap. A flit offered during a last beat starts on the very next cycle.
- R8: The receiver samples rx_width on the first beat of a flit and ignores it on later beats. Cycles in which rx_lane_valid is low are skipped. The cycle after the last beat, rx_flit_valid is high for one cycle with the reassembled header and payload.
- R9: rx_crc_err is high together with rx_flit_valid when the received CRC field differs from the CRC recomputed over the received header and payload. Otherwise it is low.
- R10: At reduced width the receiver ignores the lane bus bits outside the active quadrants.
- R11: A synchronous active-high reset stops any flit in progress on both sides and discards a partially received flit. After reset, tx_lane_valid, tx_lanes, rx_flit_valid and rx_crc_err are 0 and tx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_width | input | 2 | Send width code: 0 full, 1 half, 2 or 3 quarter |
| tx_valid | input | 1 | Flit offered for sending |
| tx_ready | output | 1 | Offered flit is accepted at this edge |
| tx_payload | input | 64 | Flit payload |
| tx_hdr | input | 8 | Flit link header |
| tx_lanes | output | 40 | Two lane slices per beat, earlier slice in the upper half |
| tx_lane_valid | output | 1 | tx_lanes carries a beat |
| rx_width | input | 2 | Receive width code, sampled on a flit's first beat |
| rx_lanes | input | 40 | Received beat, same layout as tx_lanes |
| rx_lane_valid | input | 1 | rx_lanes carries a beat |
| rx_flit_valid | output | 1 | One-cycle pulse: reassembled flit is presented |
| rx_payload | output | 64 | Received payload |
| rx_hdr | output | 8 | Received link header |
| rx_crc_err | output | 1 | Received CRC mismatch, valid with rx_flit_valid |

## Verification
The bench sweeps every width code, including the reserved one, over zero, all-ones, single-bit and random payloads. A slicing error would show up as a lane misorder or a wrong beat count, and a design that forgot the reserved code would send the wrong number of beats. It offers flits back to back with mixed widths and changes the width input in the middle of a flit. A design that sampled the width too late would switch widths mid-flit, and a design that sampled it too early would leave an idle beat or drop a flit. On receive it inserts idle cycles, puts junk on the unused lanes, drives junk width codes after the first beat and corrupts CRC fields. A receiver that failed any of these would corrupt the payload or misreport the error flag. Resets arrive in the middle of flits on both sides, and a receiver that kept stale partial state would misassemble the next flit.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;

   // Lane-group width codes; the reserved code behaves as the narrowest width.
   typedef enum logic [1:0] {
      LW_FULL    = 2'd0,
      LW_HALF    = 2'd1,
      LW_QUARTER = 2'd2,
      LW_RSVD    = 2'd3
   } lane_width_e;

   // Number of lanes carrying data for a given width code.
   function automatic int active_lanes(int total_lanes, int code);
      case (code)
         0:       return total_lanes;
         1:       return total_lanes / 2;
         default: return total_lanes / 4;
      endcase
   endfunction

   // Clock beats needed to move one flit at a given active lane count.
   function automatic int beats_per_flit(int flit_w, int slices, int lanes_on);
      return flit_w / (slices * lanes_on);
   endfunction

endpackage

// File: rtl/flit_crc_calc.sv
module flit_crc_calc #(
   parameter int                DATA_W = 72,
   parameter int                CRC_W  = 8,
   parameter logic [CRC_W-1:0]  POLY   = 'h07
) (
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);

   logic [CRC_W-1:0] rem;
   logic             fb;

   // Bit-serial division unrolled over the whole word, first bit = MSB.
   always_comb begin
      rem = '0;
      fb  = 1'b0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb  = rem[CRC_W-1] ^ data[i];
         rem = {rem[CRC_W-2:0], 1'b0};
         if (fb) begin
            rem = rem ^ POLY;
         end
      end
      crc = rem;
   end

endmodule

// File: rtl/flit_lane_serializer.sv
module flit_lane_serializer
   import flit_link_pkg::*;
#(
   parameter int FLIT_W = 80,
   parameter int LANES  = 20,
   parameter int SLICES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [FLIT_W-1:0]        in_flit,
   input  logic [1:0]               in_width,
   output logic [SLICES*LANES-1:0]  lanes,
   output logic                     lanes_valid
);

   localparam int BEAT_W    = SLICES * LANES;
   localparam int MAX_BEATS = beats_per_flit(FLIT_W, SLICES, active_lanes(LANES, 2));
   localparam int CNT_W     = $clog2(MAX_BEATS + 1);

   logic              busy;
   lane_width_e       mode;
   logic [CNT_W-1:0]  cnt;
   logic [FLIT_W-1:0] sh;
   logic              last_beat;

   logic [BEAT_W-1:0] beat_by_mode     [4];
   logic [FLIT_W-1:0] shifted_by_mode  [4];
   logic [CNT_W-1:0]  last_idx_by_mode [4];

   // One fixed slicing datapath per width code; the latched code picks one.
   for (genvar m = 0; m < 4; m++) begin : g_mode
      localparam int MW   = active_lanes(LANES, m);
      localparam int STEP = SLICES * MW;
      localparam int NB   = beats_per_flit(FLIT_W, SLICES, MW);

      logic [BEAT_W-1:0] v;

      always_comb begin
         v = '0;
         for (int j = 0; j < SLICES; j++) begin
            v[(SLICES-1-j)*LANES +: MW] = sh[FLIT_W-1-j*MW -: MW];
         end
      end

      assign beat_by_mode[m]     = v;
      assign shifted_by_mode[m]  = sh << STEP;
      assign last_idx_by_mode[m] = CNT_W'(NB - 1);
   end

   assign last_beat   = busy && (cnt == last_idx_by_mode[mode]);
   assign in_ready    = !busy || last_beat;
   assign lanes_valid = busy;
   assign lanes       = busy ? beat_by_mode[mode] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= '0;
         sh   <= '0;
         mode <= LW_FULL;
      end else if (in_valid && in_ready) begin
         busy <= 1'b1;
         cnt  <= '0;
         sh   <= in_flit;
         mode <= lane_width_e'(in_width);
      end else if (busy) begin
         cnt <= cnt + CNT_W'(1);
         sh  <= shifted_by_mode[mode];
         if (last_beat) begin
            busy <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/flit_lane_deserializer.sv
module flit_lane_deserializer
   import flit_link_pkg::*;
#(
   parameter int               FLIT_W = 80,
   parameter int               CRC_W  = 8,
   parameter int               LANES  = 20,
   parameter int               SLICES = 2,
   parameter logic [CRC_W-1:0] POLY   = 'h07
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [SLICES*LANES-1:0]  lanes,
   input  logic                     lanes_valid,
   input  logic [1:0]               in_width,
   output logic                     out_valid,
   output logic [FLIT_W-1:0]        out_flit,
   output logic                     out_crc_err
);

   localparam int BODY_W    = FLIT_W - CRC_W;
   localparam int MAX_BEATS = beats_per_flit(FLIT_W, SLICES, active_lanes(LANES, 2));
   localparam int CNT_W     = $clog2(MAX_BEATS + 1);

   logic              active;
   lane_width_e       mode;
   lane_width_e       cur_mode;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_eff;
   logic [FLIT_W-1:0] acc;
   logic [FLIT_W-1:0] base;
   logic [FLIT_W-1:0] nxt;
   logic              last_beat;
   logic [CRC_W-1:0]  crc_calc;

   logic [FLIT_W-1:0] merged_by_mode   [4];
   logic [CNT_W-1:0]  last_idx_by_mode [4];

   // Width is taken from the port only on the first beat of a flit.
   assign cur_mode = active ? mode : lane_width_e'(in_width);
   assign cnt_eff  = active ? cnt : '0;
   assign base     = active ? acc : '0;

   for (genvar m = 0; m < 4; m++) begin : g_mode
      localparam int MW   = active_lanes(LANES, m);
      localparam int STEP = SLICES * MW;
      localparam int NB   = beats_per_flit(FLIT_W, SLICES, MW);

      logic [FLIT_W-1:0] v;

      // Shift the partial flit up and append only the active lanes.
      always_comb begin
         v = base << STEP;
         for (int j = 0; j < SLICES; j++) begin
            v[(SLICES-1-j)*MW +: MW] = lanes[(SLICES-1-j)*LANES +: MW];
         end
      end

      assign merged_by_mode[m]   = v;
      assign last_idx_by_mode[m] = CNT_W'(NB - 1);
   end

   assign nxt       = merged_by_mode[cur_mode];
   assign last_beat = (cnt_eff == last_idx_by_mode[cur_mode]);

   flit_crc_calc #(
      .DATA_W (BODY_W),
      .CRC_W  (CRC_W),
      .POLY   (POLY)
   ) i_rx_crc (
      .data (nxt[BODY_W-1:0]),
      .crc  (crc_calc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         active      <= 1'b0;
         cnt         <= '0;
         acc         <= '0;
         mode        <= LW_FULL;
         out_valid   <= 1'b0;
         out_flit    <= '0;
         out_crc_err <= 1'b0;
      end else begin
         out_valid   <= 1'b0;
         out_crc_err <= 1'b0;
         if (lanes_valid) begin
            if (last_beat) begin
               active      <= 1'b0;
               cnt         <= '0;
               acc         <= '0;
               out_valid   <= 1'b1;
               out_flit    <= nxt;
               out_crc_err <= (crc_calc != nxt[FLIT_W-1 -: CRC_W]);
            end else begin
               active <= 1'b1;
               cnt    <= cnt_eff + CNT_W'(1);
               acc    <= nxt;
               mode   <= cur_mode;
            end
         end
      end
   end

endmodule

// File: rtl/flit_lane_link.sv
module flit_lane_link
   import flit_link_pkg::*;
#(
   parameter int               PAYLOAD_W      = 64,
   parameter int               HDR_W          = 8,
   parameter int               CRC_W          = 8,
   parameter int               QUAD_LANES     = 5,
   parameter int               NUM_QUADS      = 4,
   parameter int               SLICES_PER_CLK = 2,
   parameter logic [CRC_W-1:0] CRC_POLY       = 'h07
) (
   input  logic                                     clk,
   input  logic                                     rst,
   input  logic [1:0]                               tx_width,
   input  logic                                     tx_valid,
   output logic                                     tx_ready,
   input  logic [PAYLOAD_W-1:0]                     tx_payload,
   input  logic [HDR_W-1:0]                         tx_hdr,
   output logic [SLICES_PER_CLK*QUAD_LANES*NUM_QUADS-1:0] tx_lanes,
   output logic                                     tx_lane_valid,
   input  logic [1:0]                               rx_width,
   input  logic [SLICES_PER_CLK*QUAD_LANES*NUM_QUADS-1:0] rx_lanes,
   input  logic                                     rx_lane_valid,
   output logic                                     rx_flit_valid,
   output logic [PAYLOAD_W-1:0]                     rx_payload,
   output logic [HDR_W-1:0]                         rx_hdr,
   output logic                                     rx_crc_err
);

   localparam int BODY_W = PAYLOAD_W + HDR_W;
   localparam int FLIT_W = BODY_W + CRC_W;
   localparam int LANES  = QUAD_LANES * NUM_QUADS;
   localparam int QTR_W  = active_lanes(LANES, 2);

   // Elaboration-time parameter checks.
   if (NUM_QUADS % 4 != 0) begin : g_bad_quads
      $error("flit_lane_link: NUM_QUADS must be a multiple of 4");
   end
   if (FLIT_W % (SLICES_PER_CLK * QTR_W) != 0) begin : g_bad_flit
      $error("flit_lane_link: flit width must divide into whole quarter-width beats");
   end
   if (CRC_W < 2 || SLICES_PER_CLK < 1) begin : g_bad_misc
      $error("flit_lane_link: CRC_W must be at least 2 and SLICES_PER_CLK at least 1");
   end

   logic [CRC_W-1:0]  tx_crc;
   logic [FLIT_W-1:0] tx_flit;
   logic [FLIT_W-1:0] rx_flit;

   flit_crc_calc #(
      .DATA_W (BODY_W),
      .CRC_W  (CRC_W),
      .POLY   (CRC_POLY)
   ) i_tx_crc (
      .data ({tx_hdr, tx_payload}),
      .crc  (tx_crc)
   );

   assign tx_flit = {tx_crc, tx_hdr, tx_payload};

   flit_lane_serializer #(
      .FLIT_W (FLIT_W),
      .LANES  (LANES),
      .SLICES (SLICES_PER_CLK)
   ) i_ser (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (tx_valid),
      .in_ready    (tx_ready),
      .in_flit     (tx_flit),
      .in_width    (tx_width),
      .lanes       (tx_lanes),
      .lanes_valid (tx_lane_valid)
   );

   flit_lane_deserializer #(
      .FLIT_W (FLIT_W),
      .CRC_W  (CRC_W),
      .LANES  (LANES),
      .SLICES (SLICES_PER_CLK),
      .POLY   (CRC_POLY)
   ) i_des (
      .clk         (clk),
      .rst         (rst),
      .lanes       (rx_lanes),
      .lanes_valid (rx_lane_valid),
      .in_width    (rx_width),
      .out_valid   (rx_flit_valid),
      .out_flit    (rx_flit),
      .out_crc_err (rx_crc_err)
   );

   assign rx_payload = rx_flit[PAYLOAD_W-1:0];
   assign rx_hdr     = rx_flit[PAYLOAD_W +: HDR_W];

endmodule

// File: rtl/flit_lane_link_sva.sv
module flit_lane_link_sva #(
   parameter int FLIT_W = 80,
   parameter int LANES  = 20,
   parameter int SLICES = 2
) (
   input logic                     clk,
   input logic                     rst,
   input logic [1:0]               tx_width,
   input logic                     tx_valid,
   input logic                     tx_ready,
   input logic [SLICES*LANES-1:0]  tx_lanes,
   input logic                     tx_lane_valid,
   input logic                     rx_flit_valid,
   input logic                     rx_crc_err
);

   localparam int BEAT_W = SLICES * LANES;

   logic [1:0]        chk_code;
   int                beat_cnt;
   int                mw;
   int                exp_last;
   logic [BEAT_W-1:0] used_mask;

   // Width code seen at the handshake, tracked from the ports.
   always_ff @(posedge clk) begin
      if (rst) begin
         chk_code <= 2'd0;
         beat_cnt <= 0;
      end else if (tx_valid && tx_ready) begin
         chk_code <= tx_width;
         beat_cnt <= 0;
      end else if (tx_lane_valid) begin
         beat_cnt <= beat_cnt + 1;
      end
   end

   always_comb begin
      case (chk_code)
         2'd0:    mw = LANES;
         2'd1:    mw = LANES / 2;
         default: mw = LANES / 4;
      endcase
      exp_last = FLIT_W / (SLICES * mw) - 1;
      for (int i = 0; i < BEAT_W; i++) begin
         used_mask[i] = ((i % LANES) < mw);
      end
   end

   a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
      !tx_lane_valid |-> tx_ready);

   a_r7_ready_on_last_beat: assert property (@(posedge clk) disable iff (rst)
      tx_lane_valid |-> (tx_ready == (beat_cnt == exp_last)));

   a_r7_no_gap_in_flit: assert property (@(posedge clk) disable iff (rst)
      (tx_lane_valid && !tx_ready) |=> tx_lane_valid);

   a_r5_unused_lanes_zero: assert property (@(posedge clk) disable iff (rst)
      tx_lane_valid |-> ((tx_lanes & ~used_mask) == '0));

   a_r8_single_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
      rx_flit_valid |=> !rx_flit_valid);

   a_r9_err_with_valid: assert property (@(posedge clk) disable iff (rst)
      rx_crc_err |-> rx_flit_valid);

   a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!tx_lane_valid && !rx_flit_valid && tx_ready));

endmodule

bind flit_lane_link flit_lane_link_sva #(
   .FLIT_W (FLIT_W),
   .LANES  (LANES),
   .SLICES (SLICES_PER_CLK)
) i_flit_lane_link_sva (
   .clk           (clk),
   .rst           (rst),
   .tx_width      (tx_width),
   .tx_valid      (tx_valid),
   .tx_ready      (tx_ready),
   .tx_lanes      (tx_lanes),
   .tx_lane_valid (tx_lane_valid),
   .rx_flit_valid (rx_flit_valid),
   .rx_crc_err    (rx_crc_err)
);

// File: tb/test_flit_lane_link.sv
`timescale 1ns/1ps
module test_flit_lane_link;

   logic        clk;
   logic        rst;
   logic [1:0]  tx_width;
   logic        tx_valid;
   logic        tx_ready;
   logic [63:0] tx_payload;
   logic [7:0]  tx_hdr;
   logic [39:0] tx_lanes;
   logic        tx_lane_valid;
   logic [1:0]  rx_width;
   logic [39:0] rx_lanes;
   logic        rx_lane_valid;
   logic        rx_flit_valid;
   logic [63:0] rx_payload;
   logic [7:0]  rx_hdr;
   logic        rx_crc_err;

   int checks   = 0;
   int failures = 0;

   flit_lane_link i_flit_lane_link (
      .clk           (clk),
      .rst           (rst),
      .tx_width      (tx_width),
      .tx_valid      (tx_valid),
      .tx_ready      (tx_ready),
      .tx_payload    (tx_payload),
      .tx_hdr        (tx_hdr),
      .tx_lanes      (tx_lanes),
      .tx_lane_valid (tx_lane_valid),
      .rx_width      (rx_width),
      .rx_lanes      (rx_lanes),
      .rx_lane_valid (rx_lane_valid),
      .rx_flit_valid (rx_flit_valid),
      .rx_payload    (rx_payload),
      .rx_hdr        (rx_hdr),
      .rx_crc_err    (rx_crc_err)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic check(bit ok, string req, logic [79:0] act, logic [79:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R1 reference: byte-at-a-time CRC-8, polynomial 0x07, init 0.
   function automatic logic [7:0] ref_crc(logic [71:0] d);
      logic [7:0] c;
      c = 8'h00;
      for (int bi = 8; bi >= 0; bi--) begin
         c = c ^ d[bi*8 +: 8];
         for (int k = 0; k < 8; k++) begin
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
         end
      end
      return c;
   endfunction

   function automatic int lane_w(int m);
      return (m == 0) ? 20 : (m == 1) ? 10 : 5;
   endfunction

   function automatic int nbeats(int m);
      return 80 / (2 * lane_w(m));
   endfunction

   function automatic string mode_tag(int m);
      return (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
   endfunction

   function automatic logic [39:0] used_mask(int m);
      logic [39:0] r;
      for (int i = 0; i < 40; i++) r[i] = ((i % 20) < lane_w(m));
      return r;
   endfunction

   // Expected beat b of a flit at width code m.
   function automatic logic [39:0] exp_beat(logic [79:0] f, int m, int b);
      logic [39:0] r;
      int w;
      int top;
      r = '0;
      w = lane_w(m);
      for (int j = 0; j < 2; j++) begin
         top = 80 - (2 * b + j) * w;
         for (int i = 0; i < w; i++) r[(1 - j) * 20 + i] = f[top - w + i];
      end
      return r;
   endfunction

   // ---------------- transmit monitor ----------------
   logic [79:0] q_flit [$];
   int          q_mode [$];
   logic [79:0] cur_flit;
   int          cur_mode;
   int          cur_beat;
   bit          cur_on = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         q_flit.delete();
         q_mode.delete();
         cur_on = 1'b0;
      end else if (tx_lane_valid) begin
         if (!cur_on) begin
            if (q_flit.size() == 0) begin
               check(1'b0, "R7 unexpected beat", 80'(tx_lanes), 80'h0);
            end else begin
               cur_flit = q_flit.pop_front();
               cur_mode = q_mode.pop_front();
               cur_beat = 0;
               cur_on   = 1'b1;
            end
         end
         if (cur_on) begin
            check(tx_lanes == exp_beat(cur_flit, cur_mode, cur_beat), mode_tag(cur_mode),
                  80'(tx_lanes), 80'(exp_beat(cur_flit, cur_mode, cur_beat)));
            if (cur_mode != 0)
               check((tx_lanes & ~used_mask(cur_mode)) == '0, "R5 unused lanes",
                     80'(tx_lanes), 80'(exp_beat(cur_flit, cur_mode, cur_beat)));
            check(tx_ready == (cur_beat == nbeats(cur_mode) - 1), "R7 ready",
                  80'(tx_ready), 80'(cur_beat == nbeats(cur_mode) - 1));
            cur_beat++;
            if (cur_beat == nbeats(cur_mode)) cur_on = 1'b0;
         end
      end else if (cur_on || q_flit.size() > 0) begin
         check(1'b0, "R7 gap", 80'(tx_lane_valid), 80'h1);
         cur_on = 1'b0;
      end
   end

   task automatic tx_send(logic [63:0] p, logic [7:0] h, logic [1:0] m);
      @(negedge clk);
      tx_valid   = 1'b1;
      tx_payload = p;
      tx_hdr     = h;
      tx_width   = m;
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
      q_flit.push_back({ref_crc({h, p}), h, p});
      q_mode.push_back(int'(m));
      #1 tx_valid = 1'b0;
   endtask

   task automatic tx_drain();
      for (int n = 0; n < 40; n++) begin
         @(negedge clk);
         if (!tx_lane_valid && q_flit.size() == 0 && !cur_on) break;
      end
      check(tx_ready == 1'b1, "R7 idle ready", 80'(tx_ready), 80'h1);
   endtask

   // ---------------- receive driver ----------------
   task automatic rx_send(logic [79:0] f, logic [1:0] m, bit gaps, bit junk, string tag);
      int nb;
      bit exp_err;
      nb      = nbeats(int'(m));
      exp_err = (ref_crc(f[71:0]) != f[79:72]);
      for (int b = 0; b < nb; b++) begin
         @(negedge clk);
         rx_lane_valid = 1'b1;
         rx_lanes      = exp_beat(f, int'(m), b) |
                         (junk ? ({$urandom, $urandom} & ~used_mask(int'(m))) : 40'h0);
         rx_width      = (b == 0) ? m : ((m == 2'd0) ? 2'd2 : 2'd0);
         if (gaps && b < nb - 1) begin
            @(negedge clk);
            rx_lane_valid = 1'b0;
            rx_lanes      = {$urandom, $urandom};
            rx_width      = 2'd1;
         end
      end
      @(negedge clk);
      rx_lane_valid = 1'b0;
      rx_lanes      = '0;
      check(rx_flit_valid == 1'b1, {tag, " valid pulse"}, 80'(rx_flit_valid), 80'h1);
      check(rx_payload == f[63:0] && rx_hdr == f[71:64], {tag, " data"},
            80'({rx_hdr, rx_payload}), 80'(f[71:0]));
      check(rx_crc_err == exp_err, "R9 crc flag", 80'(rx_crc_err), 80'(exp_err));
      @(negedge clk);
      check(rx_flit_valid == 1'b0, "R8 pulse ends", 80'(rx_flit_valid), 80'h0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(tx_lane_valid == 1'b0 && tx_lanes == '0, "R11 tx quiet",
            80'({tx_lane_valid, tx_lanes}), 80'h0);
      check(tx_ready == 1'b1, "R11 tx ready", 80'(tx_ready), 80'h1);
      check(rx_flit_valid == 1'b0 && rx_crc_err == 1'b0, "R11 rx quiet",
            80'({rx_flit_valid, rx_crc_err}), 80'h0);
   endtask

   function automatic logic [63:0] pattern(int k, int m);
      case (k)
         0:       return 64'h0;
         1:       return '1;
         2:       return 64'h1 << (k * 13 + m * 7);
         3:       return {$urandom, $urandom};
         default: return {32{2'b10}};
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [63:0] p;
      logic [7:0]  h;
      logic [79:0] f;
      rst = 1'b1; tx_valid = 1'b0; tx_width = 2'd0; tx_payload = '0; tx_hdr = '0;
      rx_width = 2'd0; rx_lanes = '0; rx_lane_valid = 1'b0;
      do_reset();

      // R1: known CRC of an all-zero body is zero; one-bit body gives the polynomial.
      check(ref_crc(72'h0) == 8'h00 && ref_crc(72'h1) == 8'h07, "R1 crc reference",
            80'({ref_crc(72'h0), ref_crc(72'h1)}), 80'h0007);

      // Sweep all width codes over several payload patterns (R1..R5, R8, R10).
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 5; k++) begin
            p = pattern(k, m);
            h = 8'(k * 37 + m);
            tx_send(p, h, 2'(m));
            tx_drain();
            f = {ref_crc({h, p}), h, p};
            rx_send(f, 2'(m), k[0], (m != 0), (m != 0) ? "R10" : "R8");
         end
      end

      // R6: width input moved while a quarter-width flit is in flight.
      tx_send(64'h0123_4567_89AB_CDEF, 8'h5C, 2'd2);
      @(negedge clk) tx_width = 2'd0;
      repeat (3) @(negedge clk) tx_width = 2'd1;
      tx_drain();

      // R7 and R6: back-to-back flits of mixed widths, width offered during last beats.
      tx_send(64'hDEAD_BEEF_0000_FFFF, 8'hA1, 2'd0);
      tx_send(64'h1111_2222_3333_4444, 8'hB2, 2'd2);
      tx_send(64'h5555_6666_7777_8888, 8'hC3, 2'd1);
      tx_send(64'h9999_AAAA_BBBB_CCCC, 8'hD4, 2'd0);
      tx_send(64'hFEDC_BA98_7654_3210, 8'hE5, 2'd3);
      tx_drain();

      // R9: corrupted CRC field and corrupted payload bit, each width.
      for (int m = 0; m < 3; m++) begin
         p = {$urandom, $urandom};
         h = 8'(m + 8'h40);
         f = {ref_crc({h, p}) ^ 8'h01, h, p};
         rx_send(f, 2'(m), 1'b0, 1'b1, "R9");
         f = {ref_crc({h, p}), h, p ^ 64'h8000_0000_0000_0000};
         rx_send(f, 2'(m), 1'b1, 1'b0, "R9");
      end

      // R11: reset during a transmit flit.
      tx_send(64'hAAAA_5555_AAAA_5555, 8'h77, 2'd2);
      @(negedge clk);
      do_reset();

      // R11: reset discards a partial receive flit.
      f = {ref_crc({8'h12, 64'h0F0F_0F0F_F0F0_F0F0}), 8'h12, 64'h0F0F_0F0F_F0F0_F0F0};
      for (int b = 0; b < 3; b++) begin
         @(negedge clk);
         rx_lane_valid = 1'b1;
         rx_lanes      = 40'hF_FFFF_FFFF;
         rx_width      = 2'd2;
      end
      @(negedge clk) rx_lane_valid = 1'b0;
      do_reset();
      rx_send(f, 2'd0, 1'b0, 1'b0, "R11");

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule